// File: doc/BRIEF.md
# Splittable 16/32-bit ALU

This block is a registered integer ALU built from two identical 16-bit lanes. In split mode the lanes run two independent 16-bit operations side by side, each with its own set of flags. In joined mode they act as one 32-bit ALU. The low lane's carry feeds the high lane, and the flags describe the whole 32-bit result. The caller presents the operands of a register pair as one 32-bit word, with the higher-numbered register in bits 31:16.

The operation set covers add, subtract, negate, absolute value, the three bitwise logic operations, signed min and max, and single-bit set, clear and invert. It also covers bit reversal, left and arithmetic right shifts, and redundant-sign-bit counting for normalization. Three mode inputs tune the arithmetic. Saturation clamps overflowing results. Rounding makes right shifts round to nearest. Fractional mode makes left shifts behave as signed scaling with overflow detection.

Each operation takes one clock: inputs sampled at a rising edge appear at the outputs right after that edge, ready for use in the next cycle.

Top module: `split_alu`

## Requirements
- R1: All outputs are registered. Inputs sampled at a rising clock edge are reflected on the outputs right after that edge and hold until the next edge. A synchronous active-high `rst` clears every output to zero.
- R2: With `join_i`=0, lane k (k=0,1) computes on `a_i`/`b_i` bits [16k+15:16k]. It writes its result to the same bits of `y_o` and its flags to bit k of each flag output. No carry or other state passes between the lanes.
- R3: With `join_i`=1, the operation works on the full 32-bit operands. The low lane's carry out feeds the high lane's carry in. Both bits of every flag output report the flags of the 32-bit result.
- R4: Flag meanings, all taken from the final result of the active width: `gt` means signed result > 0, `ge` means signed result >= 0, and `z` means result == 0. `v` and `c` follow the per-operation rules below.
- R5: Arithmetic opcodes:
  - ADD=0 computes a+b. `c` is the unsigned carry out.
  - SUB=1 computes a-b. `c`=1 when a>=b unsigned.
  - NEG=2 computes 0-a. `c`=1 only when a==0.
  - ABS=3 computes |a|, with `c`=0.
  - For all four, `v` flags signed overflow of the true result.
- R6: With `sat_i`=1, an overflowing ADD, SUB, NEG or ABS returns the signed maximum or minimum of the active width, on the side of the true result, and `v` stays 1.
- R7: Logic and compare opcodes are AND=4, OR=5, XOR=6, MIN=7 and MAX=8. MIN and MAX are signed. All five set `v`=0 and `c`=0.
- R8: Single-bit opcodes act on a at bit index n = b mod width: BSET=9 sets bit n, BCLR=10 clears it, and BINV=11 inverts it. BREV=12 reverses the bit order of a within the width. For all four, `v`=0 and `c`=0.
- R9: SHL=13 shifts a left by n = b mod width. With `frac_i`=0 it is a logical shift with `v`=0. With `frac_i`=1, `v`=1 when the value a·2^n does not fit the signed width. If `sat_i` is also 1, such a result clamps to the extreme matching a's sign. `c`=0.
- R10: SHRA=14 shifts a arithmetically right by n = b mod width. With `rnd_i`=1 and n>0, bit n-1 of a is added to the shifted value. `v`=0 and `c`=0.
- R11: EXP=15 returns how many bits below the sign bit equal the sign bit, which is width-1 for 0 and for -1. `v`=0 and `c`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Opcode |
| join_i | input | 1 | 1 = one 32-bit operation, 0 = two 16-bit operations |
| sat_i | input | 1 | Saturate on overflow |
| rnd_i | input | 1 | Round-to-nearest on right shifts |
| frac_i | input | 1 | Fractional (signed scaling) left shift |
| a_i | input | 32 | Operand A (lane 1 in bits 31:16) |
| b_i | input | 32 | Operand B (lane 1 in bits 31:16) |
| y_o | output | 32 | Result |
| gt_o | output | 2 | Greater-than-zero flag per lane |
| ge_o | output | 2 | Greater-or-equal-zero flag per lane |
| z_o | output | 2 | Zero flag per lane |
| v_o | output | 2 | Overflow flag per lane |
| c_o | output | 2 | Carry flag per lane |

## Verification
The bench targets the lane boundary first.
- A joined 0x0000FFFF+1 must carry into bit 16. The same operands in split mode must stop at the lane edge. A broken carry link shows up as a wrong upper half in one mode or the other.
- Saturation is driven with operands at the signed extremes, including |MIN| and a fractional left shift of 0x4000. A design that picks the wrong clamp side or drops `v` returns a wrapped or sign-flipped value.
- Rounded right shifts of small negative values and sign-bit counting of 0 and -1 catch off-by-one errors in bit selection.
- Random operands biased toward 0, 1, -1, MAX and MIN catch flags that are taken from a single lane instead of the active width.

// File: rtl/split_alu_pkg.sv
package split_alu_pkg;

    localparam int LANE_W    = 16;
    localparam int NUM_LANES = 2;
    localparam int FULL_W    = LANE_W * NUM_LANES;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_NEG  = 4'd2,
        OP_ABS  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_MIN  = 4'd7,
        OP_MAX  = 4'd8,
        OP_BSET = 4'd9,
        OP_BCLR = 4'd10,
        OP_BINV = 4'd11,
        OP_BREV = 4'd12,
        OP_SHL  = 4'd13,
        OP_SHRA = 4'd14,
        OP_EXP  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic gt;
        logic ge;
        logic z;
        logic v;
        logic c;
    } alu_flags_t;

    typedef struct packed {
        logic sat;
        logic rnd;
        logic frac;
    } alu_mode_t;

    // Operations that run the adder as x + ~y + 1
    function automatic logic adder_inverts(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_NEG) || (op == OP_ABS);
    endfunction

    // Operations whose adder x input is forced to zero
    function automatic logic adder_zero_x(input alu_op_e op);
        return (op == OP_NEG) || (op == OP_ABS);
    endfunction

endpackage

// File: rtl/alu_adder_slice.sv
module alu_adder_slice #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] low_sum;
    logic         c_into_msb;
    logic [1:0]   top_sum;

    // Lower W-1 bits with their carry, then the sign bit separately,
    // so the carry into the sign position is available for overflow.
    assign low_sum  = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, cin};
    assign c_into_msb = low_sum[W-1];
    assign top_sum  = {1'b0, x[W-1]} + {1'b0, y[W-1]} + {1'b0, c_into_msb};

    assign sum  = {top_sum[0], low_sum[W-2:0]};
    assign cout = top_sum[1];
    assign ovf  = top_sum[1] ^ c_into_msb;
endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import split_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e    op,
    input  alu_mode_t  mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] sum,
    input  logic         cout,
    input  logic         ovf,
    output logic [W-1:0] res,
    output alu_flags_t   flags
);
    localparam int SW = $clog2(W);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [SW-1:0] amt;
    logic [W-1:0]  bit_mask;
    logic [W-1:0]  shl_val;
    logic [W-1:0]  shl_back;
    logic          shl_ovf;
    logic [W-1:0]  shr_val;
    logic          rnd_bit;
    logic [W-1:0]  rev_val;
    logic [SW-1:0] sign_cnt;
    logic          a_lt_b;

    function automatic logic [SW-1:0] count_sign_bits(input logic [W-1:0] val);
        logic [SW-1:0] cnt;
        logic          run;
        cnt = '0;
        run = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (val[i] == val[W-1])) cnt = cnt + 1'b1;
            else run = 1'b0;
        end
        return cnt;
    endfunction

    assign amt      = b[SW-1:0];
    assign bit_mask = {{(W-1){1'b0}}, 1'b1} << amt;
    assign shl_val  = a << amt;
    assign shl_back = W'($signed(shl_val) >>> amt);
    assign shl_ovf  = (shl_back != a);
    assign shr_val  = W'($signed(a) >>> amt);
    assign rnd_bit  = |(a & (bit_mask >> 1));
    assign sign_cnt = count_sign_bits(a);
    assign a_lt_b   = $signed(a) < $signed(b);

    always_comb begin
        for (int i = 0; i < W; i++) rev_val[i] = a[W-1-i];
    end

    always_comb begin
        res     = '0;
        flags.v = 1'b0;
        flags.c = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_NEG: begin
                res     = sum;
                flags.c = cout;
                flags.v = ovf;
                if (mode.sat && ovf) res = sum[W-1] ? MAXV : MINV;
            end
            OP_ABS: begin
                if (a[W-1]) begin
                    res     = sum;
                    flags.v = ovf;
                    if (mode.sat && ovf) res = MAXV;
                end else begin
                    res = a;
                end
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_MIN:  res = a_lt_b ? a : b;
            OP_MAX:  res = a_lt_b ? b : a;
            OP_BSET: res = a | bit_mask;
            OP_BCLR: res = a & ~bit_mask;
            OP_BINV: res = a ^ bit_mask;
            OP_BREV: res = rev_val;
            OP_SHL: begin
                res = shl_val;
                if (mode.frac) begin
                    flags.v = shl_ovf;
                    if (mode.sat && shl_ovf) res = a[W-1] ? MINV : MAXV;
                end
            end
            OP_SHRA: res = shr_val + (mode.rnd ? {{(W-1){1'b0}}, rnd_bit} : '0);
            OP_EXP:  res = {{(W-SW){1'b0}}, sign_cnt};
            default: res = '0;
        endcase
        flags.z  = (res == '0);
        flags.ge = ~res[W-1];
        flags.gt = ~res[W-1] && (res != '0);
    end
endmodule

// File: rtl/split_alu.sv
module split_alu
    import split_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  op_i,
    input  logic        join_i,
    input  logic        sat_i,
    input  logic        rnd_i,
    input  logic        frac_i,
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    output logic [31:0] y_o,
    output logic [1:0]  gt_o,
    output logic [1:0]  ge_o,
    output logic [1:0]  z_o,
    output logic [1:0]  v_o,
    output logic [1:0]  c_o
);
    localparam int LW = LANE_W;
    localparam int NL = NUM_LANES;
    localparam int FW = FULL_W;

    alu_op_e   op;
    alu_mode_t mode;
    logic      base_cin;

    logic [NL-1:0][LW-1:0] lane_sum;
    logic [NL-1:0]         lane_cout;
    logic [NL-1:0]         lane_ovf;
    logic [NL-1:0]         lane_cin;
    logic [NL-1:0][LW-1:0] lane_res;
    alu_flags_t [NL-1:0]   lane_flags;

    logic [FW-1:0] wide_res;
    alu_flags_t    wide_flags;

    logic [FW-1:0]       y_next;
    alu_flags_t [NL-1:0] f_next;
    logic [FW-1:0]       y_q;
    alu_flags_t [NL-1:0] f_q;

    assign op       = alu_op_e'(op_i);
    assign mode     = '{sat: sat_i, rnd: rnd_i, frac: frac_i};
    assign base_cin = adder_inverts(op);

    for (genvar k = 0; k < NL; k++) begin : g_lane
        logic [LW-1:0] a_l, b_l, x_l, y_l;
        assign a_l = a_i[k*LW +: LW];
        assign b_l = b_i[k*LW +: LW];
        assign x_l = adder_zero_x(op) ? '0 : a_l;
        assign y_l = adder_zero_x(op) ? ~a_l : (op == OP_SUB) ? ~b_l : b_l;

        if (k == 0) begin : g_first
            assign lane_cin[k] = base_cin;
        end else begin : g_chain
            assign lane_cin[k] = join_i ? lane_cout[k-1] : base_cin;
        end

        alu_adder_slice #(.W(LW)) u_add (
            .x   (x_l),
            .y   (y_l),
            .cin (lane_cin[k]),
            .sum (lane_sum[k]),
            .cout(lane_cout[k]),
            .ovf (lane_ovf[k])
        );

        alu_unit #(.W(LW)) u_unit (
            .op   (op),
            .mode (mode),
            .a    (a_l),
            .b    (b_l),
            .sum  (lane_sum[k]),
            .cout (lane_cout[k]),
            .ovf  (lane_ovf[k]),
            .res  (lane_res[k]),
            .flags(lane_flags[k])
        );
    end

    alu_unit #(.W(FW)) u_wide (
        .op   (op),
        .mode (mode),
        .a    (a_i),
        .b    (b_i),
        .sum  (lane_sum),
        .cout (lane_cout[NL-1]),
        .ovf  (lane_ovf[NL-1]),
        .res  (wide_res),
        .flags(wide_flags)
    );

    always_comb begin
        if (join_i) begin
            y_next = wide_res;
            for (int k = 0; k < NL; k++) f_next[k] = wide_flags;
        end else begin
            y_next = lane_res;
            f_next = lane_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
            f_q <= '0;
        end else begin
            y_q <= y_next;
            f_q <= f_next;
        end
    end

    assign y_o = y_q;
    always_comb begin
        for (int k = 0; k < NL; k++) begin
            gt_o[k] = f_q[k].gt;
            ge_o[k] = f_q[k].ge;
            z_o[k]  = f_q[k].z;
            v_o[k]  = f_q[k].v;
            c_o[k]  = f_q[k].c;
        end
    end
endmodule

// File: rtl/split_alu_chk.sv
module split_alu_chk
    import split_alu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_i,
    input logic        join_i,
    input logic        sat_i,
    input logic        rnd_i,
    input logic        frac_i,
    input logic [31:0] a_i,
    input logic [31:0] b_i,
    input logic [31:0] y_o,
    input logic [1:0]  gt_o,
    input logic [1:0]  ge_o,
    input logic [1:0]  z_o,
    input logic [1:0]  v_o,
    input logic [1:0]  c_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (y_o == '0 && gt_o == '0 && ge_o == '0 && z_o == '0 && v_o == '0 && c_o == '0));

    assert_joined_flags_match_R3: assert property (@(posedge clk) disable iff (rst)
        $past(join_i) |-> (gt_o[0] == gt_o[1] && ge_o[0] == ge_o[1] && z_o[0] == z_o[1]
                           && v_o[0] == v_o[1] && c_o[0] == c_o[1]));

    assert_flag_consistency_R4: assert property (@(posedge clk) disable iff (rst)
        ((z_o & gt_o) == 2'b00) && (((gt_o | z_o) & ~ge_o) == 2'b00));

    assert_sat_clamp_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(join_i && sat_i && op_i == OP_ADD) && v_o[0])
        |-> (y_o == 32'h7FFF_FFFF || y_o == 32'h8000_0000));

    assert_logic_no_vc_R7: assert property (@(posedge clk) disable iff (rst)
        $past(op_i inside {OP_AND, OP_OR, OP_XOR, OP_MIN, OP_MAX}) |-> (v_o == 2'b00 && c_o == 2'b00));

    assert_exp_range_R11: assert property (@(posedge clk) disable iff (rst)
        $past(!join_i && op_i == OP_EXP) |-> (y_o[15:0] <= 16'd15 && y_o[31:16] <= 16'd15));
endmodule

bind split_alu split_alu_chk u_chk (.*);

// File: tb/tb_split_alu.sv
`timescale 1ns/1ps
module tb_split_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic        join_i = 1'b0, sat_i = 1'b0, rnd_i = 1'b0, frac_i = 1'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [31:0] y_o;
    logic [1:0]  gt_o, ge_o, z_o, v_o, c_o;

    int total = 0;
    int bad   = 0;

    split_alu dut (.*);

    always #5 clk = ~clk;

    // Reference model from the requirements, any width up to 32
    function automatic void ref_op(input int w, input logic [3:0] op, input logic [31:0] a_in,
                                   input logic [31:0] b_in, input logic sat, input logic rnd,
                                   input logic frac, output logic [31:0] r, output logic c,
                                   output logic v);
        longint mask = (longint'(1) << w) - 1;
        longint mx   = (longint'(1) << (w - 1)) - 1;
        longint mn   = -(longint'(1) << (w - 1));
        longint ua   = longint'(a_in) & mask;
        longint ub   = longint'(b_in) & mask;
        longint sa   = (ua > mx) ? ua - (longint'(1) << w) : ua;
        longint sb   = (ub > mx) ? ub - (longint'(1) << w) : ub;
        int     amt  = int'(ub & longint'(w - 1));
        longint t, rr;
        c = 1'b0; v = 1'b0; rr = 0; t = 0;
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                if (op == 4'd0) begin t = sa + sb; c = ((ua + ub) >> w) & 1; end
                if (op == 4'd1) begin t = sa - sb; c = (ua >= ub); end
                if (op == 4'd2) begin t = -sa;     c = (ua == 0);  end
                if (op == 4'd3) t = (sa < 0) ? -sa : sa;
                v  = (t > mx) || (t < mn);
                rr = (sat && v) ? ((t > 0) ? mx : mn) : t;
            end
            4'd4: rr = ua & ub;
            4'd5: rr = ua | ub;
            4'd6: rr = ua ^ ub;
            4'd7: rr = (sa < sb) ? sa : sb;
            4'd8: rr = (sa < sb) ? sb : sa;
            4'd9:  rr = ua | (longint'(1) << amt);
            4'd10: rr = ua & ~(longint'(1) << amt);
            4'd11: rr = ua ^ (longint'(1) << amt);
            4'd12: for (int i = 0; i < w; i++) if (ua[i]) rr = rr | (longint'(1) << (w - 1 - i));
            4'd13: begin
                rr = ua << amt;
                if (frac) begin
                    t = sa * (longint'(1) << amt);
                    v = (t > mx) || (t < mn);
                    if (sat && v) rr = (sa < 0) ? mn : mx;
                end
            end
            4'd14: begin
                rr = sa >>> amt;
                if (rnd && amt > 0) rr = rr + ((ua >> (amt - 1)) & 1);
            end
            default: begin
                for (int i = w - 2; i >= 0; i--) begin
                    if (ua[i] == ua[w-1]) rr = rr + 1;
                    else break;
                end
            end
        endcase
        r = 32'(rr & mask);
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        if (op <= 4'd3) return "R5";
        if (op <= 4'd8) return "R7";
        if (op <= 4'd12) return "R8";
        if (op == 4'd13) return "R9";
        if (op == 4'd14) return "R10";
        return "R11";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (op=%0d join=%0b sat=%0b rnd=%0b frac=%0b a=%h b=%h)",
                     tag, act, exp, op_i, join_i, sat_i, rnd_i, frac_i, a_i, b_i);
        end
    endtask

    // Called at a negedge: drive, let one rising edge pass, check at next negedge
    task automatic run(input logic [3:0] op, input logic jn, input logic sat, input logic rnd,
                       input logic frac, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r0, r1, rw, ey;
        logic c0, c1, cw, v0, v1, vw;
        logic [1:0] egt, ege, ez, ev, ec;
        string tag, mtag;
        op_i = op; join_i = jn; sat_i = sat; rnd_i = rnd; frac_i = frac; a_i = a; b_i = b;
        @(negedge clk);
        if (jn) begin
            ref_op(32, op, a, b, sat, rnd, frac, rw, cw, vw);
            ey  = rw;
            egt = {2{~rw[31] && rw != 0}}; ege = {2{~rw[31]}}; ez = {2{rw == 0}};
            ev  = {2{vw}}; ec = {2{cw}};
            mtag = "R3";
        end else begin
            ref_op(16, op, {16'h0, a[15:0]}, {16'h0, b[15:0]}, sat, rnd, frac, r0, c0, v0);
            ref_op(16, op, {16'h0, a[31:16]}, {16'h0, b[31:16]}, sat, rnd, frac, r1, c1, v1);
            ey  = {r1[15:0], r0[15:0]};
            egt = {~r1[15] && r1 != 0, ~r0[15] && r0 != 0};
            ege = {~r1[15], ~r0[15]}; ez = {r1 == 0, r0 == 0};
            ev  = {v1, v0}; ec = {c1, c0};
            mtag = "R2";
        end
        tag = (sat && (ev != 0) && op != 4'd13) ? "R6" : op_tag(op);
        check({tag, "/", mtag, " result"}, y_o, ey);
        check({"R4/", mtag, " gt ge z"}, {26'h0, gt_o, ge_o, z_o}, {26'h0, egt, ege, ez});
        check({tag, "/", mtag, " v c"}, {28'h0, v_o, c_o}, {28'h0, ev, ec});
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h0000_0000;
            1: return 32'h0001_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_8000;
            4: return 32'h7FFF_7FFF;
            5: return {$urandom_range(0, 65535) > 32767 ? 16'h8000 : 16'h7FFF, 16'(($urandom()))};
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset y", y_o, 32'h0);
        check("R1 reset flags", {22'h0, gt_o, ge_o, z_o, v_o, c_o}, 32'h0);
        rst = 1'b0;

        // Directed corners
        run(4'd0, 1, 0, 0, 0, 32'h0000_FFFF, 32'h0000_0001);   // R3 carry crosses lanes
        run(4'd0, 0, 0, 0, 0, 32'h0000_FFFF, 32'h0000_0001);   // R2 carry stops at lane edge
        run(4'd0, 0, 1, 0, 0, 32'h7FFF_8000, 32'h0001_FFFF);   // R6 both clamp sides
        run(4'd1, 1, 1, 0, 0, 32'h8000_0000, 32'h0000_0001);   // R6 joined min
        run(4'd3, 0, 1, 0, 0, 32'h8000_8000, 32'h0);           // R6 abs of min
        run(4'd2, 1, 0, 0, 0, 32'h0, 32'h0);                   // R5 negate zero carry
        run(4'd14, 0, 0, 1, 0, 32'hFFFD_0003, 32'h0001_0001);  // R10 rounding
        run(4'd14, 1, 0, 1, 0, 32'h8000_0001, 32'h0);          // R10 zero shift no round
        run(4'd13, 0, 1, 0, 1, 32'hC000_4000, 32'h0002_0001);  // R9 frac clamp
        run(4'd13, 0, 0, 0, 0, 32'hC000_4000, 32'h0002_0001);  // R9 logical
        run(4'd15, 0, 0, 0, 0, 32'hFFFF_0000, 32'h0);          // R11 both full counts
        run(4'd15, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'h0);          // R11 joined -1
        run(4'd12, 1, 0, 0, 0, 32'h0000_0001, 32'h0);          // R8 reverse
        run(4'd9, 1, 0, 0, 0, 32'h0, 32'h0000_001F);           // R8 top bit set
        run(4'd7, 0, 0, 0, 0, 32'h8000_7FFF, 32'h7FFF_8000);   // R7 signed min

        // R1: outputs hold between edges
        held = y_o;
        op_i = 4'd6; a_i = 32'h1234_5678; b_i = 32'hFFFF_0000;
        #2;
        check("R1 hold between edges", y_o, held);
        @(negedge clk);

        for (int n = 0; n < 3000; n++) begin
            run(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), pick(), pick());
        end

        // R1: synchronous reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", {y_o[31:10], gt_o, ge_o, z_o, v_o, c_o}, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule